// File: doc/BRIEF.md
# Power Mode Transition Validator

This block holds the chip's current power mode and screens every request to change it. A requester raises a one-cycle strobe with a 3-bit target mode; the block either applies the target on the next clock edge or refuses it, leaves the mode as it was and records why. Active-to-active changes are screened against a table of supported pairs. Entry into the two deepest sleep levels is screened against the current core level. Entry into the deep sleep and shutdown modes is also screened against live static requests on the system clock lines.

Each of the three refusal causes has its own sticky flag, its own write-one clear bit and its own interrupt enable. A single registered interrupt output reports any enabled flag. A small register-style write port loads the enables and a force bit. When the force bit is set, deep entry goes ahead even while clocks are still requested. Voltage regulation, clock gating and wake-up sequencing are handled elsewhere.

Top module: `pmode_guard`

## Requirements
- R1: After reset, the current mode equals RESET_MODE (default 0), all three flags, the enables, the force bit and the interrupt are 0.
- R2: Mode codes are 0 = active LDO core0, 1 = active LDO core1, 2 = active DC-DC core0, 3 = active DC-DC core1, 4 = light sleep, 5 = sleep level 3, 6 = sleep level 4, 7 = shutdown. Bit 1 selects the regulator and bit 0 the core level. An accepted request makes the mode equal to the target on the first edge after the strobe. Between active modes this happens when the two modes share the regulator bit or the core-level bit.
- R3: An active-to-active request between modes that share neither bit (0 and 3, 1 and 2) sets flag bit 0 and leaves the mode unchanged.
- R4: A request for mode 5 or 6 from active mode 1 or 3 sets flag bit 1 and leaves the mode unchanged. No clock flag is raised for this request.
- R5: A request for mode 4 from any active mode is accepted whatever the clock requests and the force bit.
- R6: A request for mode 5 or 6 from mode 0 or 2, or for mode 7 from any active mode, is refused while any clk_req bit is 1 and the force bit is 0. The refusal sets flag bit 2 and leaves the mode unchanged.
- R7: With the force bit at 1, the requests of R6 are accepted even while clock requests are active.
- R8: While the current mode is a sleep or shutdown mode (4 to 7), any request is applied without checks.
- R9: A flag stays at 1 until a write with cfg_we=1 carries a 1 in its clear bit: cfg_wdata[4] clears flag 0, [5] clears flag 1, [6] clears flag 2.
- R10: If a refusal and the clear of the same flag fall in one cycle, the flag ends at 1.
- R11: irq is the OR of each flag ANDed with its enable, registered: it reflects flags and enables one cycle after they change. A flag whose enable is 0 never raises irq.
- R12: A write with cfg_we=1 loads the enables from cfg_wdata[2:0] (bit i enables flag i) and the force bit from cfg_wdata[3]. These values hold until the next write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode change request strobe |
| req_mode | input | 3 | Target mode code |
| clk_req | input | NUM_CLK (4) | Static request per system clock line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Enables [2:0], force [3], clear bits [6:4] |
| cur_mode | output | 3 | Current power mode |
| err_flags | output | 3 | Sticky flags: active transition, deep transition, clock |
| irq | output | 1 | Combined registered interrupt |

## Verification
Two things can fall in one cycle: a refused request that raises a flag, and a configuration write that clears the same flag. The bench forces this overlap in directed cases for each flag. Its random stimulus also mixes requests and writes with clear bits set, so the overlap keeps recurring. A bench model where the event wins predicts every flag and the registered irq, and the bench compares them with the outputs in each cycle.

// File: rtl/pmg_pkg.sv
package pmg_pkg;
   localparam int MODE_W   = 3;
   localparam int NUM_FLAG = 3;
   localparam int CFG_W    = 2 * NUM_FLAG + 1;

   localparam logic [MODE_W-1:0] PM_LIGHT = 3'd4;
   localparam logic [MODE_W-1:0] PM_SHUT  = 3'd7;

   localparam int FLG_ACT = 0;
   localparam int FLG_DEEP = 1;
   localparam int FLG_CLK = 2;

   function automatic logic pm_active(input logic [MODE_W-1:0] m);
      return ~m[2];
   endfunction

   function automatic logic pm_core_hi(input logic [MODE_W-1:0] m);
      return m[0];
   endfunction

   function automatic logic pm_reg_sel(input logic [MODE_W-1:0] m);
      return m[1];
   endfunction

   function automatic logic pm_deep_lvl(input logic [MODE_W-1:0] m);
      return m[2] & (m[1] ^ m[0]);
   endfunction

   function automatic logic pm_clk_gated(input logic [MODE_W-1:0] m);
      return m[2] & (m[1] | m[0]);
   endfunction
endpackage

// File: rtl/pmg_rule_check.sv
module pmg_rule_check
   import pmg_pkg::*;
#(
   parameter int NUM_CLK = 4
) (
   input  logic [MODE_W-1:0]  cur_mode,
   input  logic [MODE_W-1:0]  tgt_mode,
   input  logic [NUM_CLK-1:0] clk_req,
   input  logic               force_entry,
   output logic               accept,
   output logic               ev_act,
   output logic               ev_deep,
   output logic               ev_clk
);
   logic any_clk;
   logic shares;

   assign any_clk = |clk_req;
   assign shares  = (pm_reg_sel(cur_mode) == pm_reg_sel(tgt_mode)) ||
                    (pm_core_hi(cur_mode) == pm_core_hi(tgt_mode));

   always_comb begin
      accept  = 1'b0;
      ev_act  = 1'b0;
      ev_deep = 1'b0;
      ev_clk  = 1'b0;
      if (!pm_active(cur_mode)) begin
         accept = 1'b1;
      end else if (pm_active(tgt_mode)) begin
         accept = shares;
         ev_act = ~shares;
      end else if (tgt_mode == PM_LIGHT) begin
         accept = 1'b1;
      end else if (pm_deep_lvl(tgt_mode) && pm_core_hi(cur_mode)) begin
         ev_deep = 1'b1;
      end else if (pm_clk_gated(tgt_mode) && any_clk && !force_entry) begin
         ev_clk = 1'b1;
      end else begin
         accept = 1'b1;
      end
   end

   always_comb begin
      assert_one_outcome_R3: assert ($countones({accept, ev_act, ev_deep, ev_clk}) == 1);
   end
endmodule

// File: rtl/pmg_flag_bank.sv
module pmg_flag_bank #(
   parameter int NUM_FLAG = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FLAG-1:0] set_ev,
   input  logic [NUM_FLAG-1:0] clr_req,
   output logic [NUM_FLAG-1:0] flags
);
   for (genvar i = 0; i < NUM_FLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flags[i] <= 1'b0;
         else if (set_ev[i])  flags[i] <= 1'b1;
         else if (clr_req[i]) flags[i] <= 1'b0;
      end

      assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !clr_req[i]) |=> flags[i]);
      assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
         set_ev[i] |=> flags[i]);
      assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_req[i] && !set_ev[i]) |=> !flags[i]);
   end
endmodule

// File: rtl/pmg_irq_merge.sv
module pmg_irq_merge #(
   parameter int NUM_FLAG = 3,
   parameter bit IRQ_REG  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FLAG-1:0] flags,
   input  logic [NUM_FLAG-1:0] enables,
   output logic                irq
);
   logic raw;
   assign raw = |(flags & enables);

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= raw;
      end
      assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(flags & enables)) |=> !irq);
      assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (|(flags & enables)) |=> irq);
   end else begin : g_comb
      assign irq = raw;
   end
endmodule

// File: rtl/pmode_guard.sv
module pmode_guard
   import pmg_pkg::*;
#(
   parameter int NUM_CLK            = 4,
   parameter logic [2:0] RESET_MODE = 3'd0,
   parameter bit IRQ_REG            = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [2:0]         req_mode,
   input  logic [NUM_CLK-1:0] clk_req,
   input  logic               cfg_we,
   input  logic [6:0]         cfg_wdata,
   output logic [2:0]         cur_mode,
   output logic [2:0]         err_flags,
   output logic               irq
);
   localparam int FORCE_BIT = NUM_FLAG;
   localparam int CLR_LSB   = NUM_FLAG + 1;

   if (NUM_CLK < 1) begin : g_bad_clk
      $error("pmode_guard: NUM_CLK must be at least 1");
   end
   if (RESET_MODE[2]) begin : g_bad_reset
      $error("pmode_guard: RESET_MODE must be an active mode");
   end
   if (CFG_W != 7) begin : g_bad_cfg
      $error("pmode_guard: configuration width mismatch");
   end

   logic [NUM_FLAG-1:0] en_q;
   logic                force_q;
   logic                accept, ev_act, ev_deep, ev_clk;
   logic [NUM_FLAG-1:0] set_ev, clr_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         force_q <= 1'b0;
      end else if (cfg_we) begin
         en_q    <= cfg_wdata[NUM_FLAG-1:0];
         force_q <= cfg_wdata[FORCE_BIT];
      end
   end

   pmg_rule_check #(.NUM_CLK(NUM_CLK)) u_rule (
      .cur_mode    (cur_mode),
      .tgt_mode    (req_mode),
      .clk_req     (clk_req),
      .force_entry (force_q),
      .accept      (accept),
      .ev_act      (ev_act),
      .ev_deep     (ev_deep),
      .ev_clk      (ev_clk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cur_mode <= RESET_MODE;
      else if (req_valid && accept)  cur_mode <= req_mode;
   end

   always_comb begin
      set_ev           = '0;
      set_ev[FLG_ACT]  = req_valid & ev_act;
      set_ev[FLG_DEEP] = req_valid & ev_deep;
      set_ev[FLG_CLK]  = req_valid & ev_clk;
      clr_req          = cfg_we ? cfg_wdata[CLR_LSB +: NUM_FLAG] : '0;
   end

   pmg_flag_bank #(.NUM_FLAG(NUM_FLAG)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ev  (set_ev),
      .clr_req (clr_req),
      .flags   (err_flags)
   );

   pmg_irq_merge #(.NUM_FLAG(NUM_FLAG), .IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   (err_flags),
      .enables (en_q),
      .irq     (irq)
   );

   // R3, R4 and R6: a refused request keeps the mode
   assert_reject_keeps_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !accept) |=> (cur_mode == $past(cur_mode)));
   assert_accept_applies_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && accept) |=> (cur_mode == $past(req_mode)));
   assert_shutdown_clk_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cur_mode[2] && req_mode == PM_SHUT && (|clk_req) && !force_q)
      |=> err_flags[FLG_CLK]);
   assert_light_sleep_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cur_mode[2] && req_mode == PM_LIGHT) |=> (cur_mode == PM_LIGHT));
   assert_sleep_exit_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cur_mode[2]) |=> (cur_mode == $past(req_mode)));
endmodule

// File: tb/pmode_guard_tb.sv
module pmode_guard_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_mode = '0;
   logic [3:0] clk_req = '0;
   logic       cfg_we = 1'b0;
   logic [6:0] cfg_wdata = '0;
   logic [2:0] cur_mode;
   logic [2:0] err_flags;
   logic       irq;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [2:0] m_mode;
   logic [2:0] m_flags;
   logic [2:0] m_en;
   logic       m_force;
   logic       m_irq;

   always #4 clk = ~clk;

   pmode_guard u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .clk_req(clk_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cur_mode(cur_mode), .err_flags(err_flags), .irq(irq)
   );

   function automatic logic act(input logic [2:0] m);
      return ~m[2];
   endfunction

   // Expected outcome: 0 accept, 1 flag0, 2 flag1, 3 flag2
   function automatic int judge(input logic [2:0] cur, input logic [2:0] tgt,
                                input logic [3:0] ck, input logic frc);
      if (!act(cur)) return 0;
      if (act(tgt)) return ((cur[1] == tgt[1]) || (cur[0] == tgt[0])) ? 0 : 1;
      if (tgt == 3'd4) return 0;
      if ((tgt == 3'd5 || tgt == 3'd6) && cur[0]) return 2;
      if ((|ck) && !frc) return 3;
      return 0;
   endfunction

   function automatic string tag_of(input logic [2:0] cur, input logic [2:0] tgt,
                                    input logic [3:0] ck, input logic frc);
      int j;
      j = judge(cur, tgt, ck, frc);
      if (!act(cur)) return "R8";
      if (j == 1) return "R3";
      if (j == 2) return "R4";
      if (j == 3) return "R6";
      if (tgt == 3'd4) return "R5";
      if (tgt[2] && (|ck) && frc) return "R7";
      return "R2";
   endfunction

   task automatic check(input string tag, input string what, input int act_v, input int exp_v);
      checks++;
      if (act_v != exp_v) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act_v, exp_v);
      end
   endtask

   // apply current inputs for one edge, advance the model, compare after the edge
   task automatic step(input string tag);
      int j;
      logic [2:0] ev, clr, nf;
      j = 0;
      ev = '0;
      if (req_valid) j = judge(m_mode, req_mode, clk_req, m_force);
      if (j > 0) ev[j-1] = 1'b1;
      clr = cfg_we ? cfg_wdata[6:4] : 3'b000;
      nf = ev | (m_flags & ~clr);
      @(posedge clk);
      @(negedge clk);
      m_irq = |(m_flags & m_en);
      if (req_valid && j == 0) m_mode = req_mode;
      m_flags = nf;
      if (cfg_we) begin
         m_en = cfg_wdata[2:0];
         m_force = cfg_wdata[3];
      end
      check(tag, "cur_mode", int'(cur_mode), int'(m_mode));
      check(tag, "err_flags", int'(err_flags), int'(m_flags));
      check("R11", "irq", int'(irq), int'(m_irq));
      req_valid = 1'b0;
      cfg_we = 1'b0;
   endtask

   task automatic req(input logic [2:0] tgt, input logic [3:0] ck);
      string t;
      t = tag_of(m_mode, tgt, ck, m_force);
      req_valid = 1'b1;
      req_mode = tgt;
      clk_req = ck;
      step(t);
   endtask

   task automatic cfg(input logic [6:0] d, input string tag);
      cfg_we = 1'b1;
      cfg_wdata = d;
      step(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_mode = 3'd0; m_flags = '0; m_en = '0; m_force = 1'b0; m_irq = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "cur_mode", int'(cur_mode), 0);
      check("R1", "err_flags", int'(err_flags), 0);
      check("R1", "irq", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      step("R1");

      // R12 enables on, force off; R2 supported active change
      cfg(7'b000_0111, "R12");
      req(3'd1, 4'b0000);                 // R2 0->1
      req(3'd2, 4'b0000);                 // R3 1->2 refused
      step("R11");                        // irq rises one cycle later
      req(3'd5, 4'b0000);                 // R4 1->5 refused
      req(3'd0, 4'b0000);                 // R2 back to 0
      req(3'd5, 4'b0100);                 // R6 clock deny
      cfg(7'b111_0000, "R9");             // clear all, enables off
      step("R11");
      req(3'd4, 4'b1111);                 // R5 light sleep with clocks
      req(3'd3, 4'b0000);                 // R8 wake to 3 unchecked
      req(3'd0, 4'b0000);                 // R3 3->0 refused (sets flag0, no irq)
      step("R11");
      // R10: event and clear same cycle
      req_valid = 1'b1; req_mode = 3'd0; clk_req = '0;
      cfg_we = 1'b1; cfg_wdata = 7'b001_0001;
      step("R10");
      req(3'd1, 4'b0000);
      req(3'd0, 4'b0000);
      // R12 force bit then R7
      cfg(7'b000_1000, "R12");
      req(3'd7, 4'b0010);                 // R7 forced shutdown
      req(3'd2, 4'b0000);                 // R8
      req(3'd6, 4'b1000);                 // R7 forced sleep4
      req(3'd0, 4'b0000);
      cfg(7'b000_0000, "R12");
      req(3'd7, 4'b0001);                 // R6 shutdown denied
      req(3'd6, 4'b0000);                 // R2 path accept, no clocks
      req(3'd0, 4'b0000);
      // R10 for clock flag
      req_valid = 1'b1; req_mode = 3'd5; clk_req = 4'b0001;
      cfg_we = 1'b1; cfg_wdata = 7'b100_0100;
      step("R10");
      step("R11");

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r < 6) begin
            logic [3:0] ck;
            ck = ($urandom_range(0, 2) == 0) ? 4'b0000 : 4'($urandom());
            if (r < 2) begin
               cfg_we = 1'b1;
               cfg_wdata = 7'($urandom());
            end
            req(3'($urandom()), ck);
         end else if (r < 8) begin
            cfg(7'($urandom()), "R9");
         end else begin
            step("R9");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule